// File: doc/BRIEF.md
# TV Line Horizontal Timing Generator

This block produces the horizontal timing of one analog television line, one pixel clock at a time. A position counter runs from zero to a programmed last-pixel value and then wraps. Four outputs are decoded from it: a horizontal sync pulse, a horizontal blanking window, a colour-burst gate and a single-cycle strobe that marks the first pixel of each line. Every position is counted from the first pixel of sync, and that first pixel is position zero. A programmed value N therefore names pixel N+1 of the line.

All six position settings and the burst-enable bit are captured into shadow registers only when a line begins. A line begins on the first enabled cycle, or when the counter wraps. Software can rewrite the inputs at any time, and a line already in progress never mixes old and new values. The burst gate serves composite and S-video style outputs. A component-video configuration leaves burst enable clear, and the gate then stays low.

When the enable input is low, the counter returns to zero and all outputs fall low. When enable is raised again, a new line starts at position zero.

Top module: `tv_hline_gen`

## Requirements
- R1: The line position starts at 0 on the first enabled cycle. It advances by one each clock and returns to 0 after reaching `line_last`, so a line lasts `line_last`+1 clocks.
- R2: `hsync` is high exactly while position < `hsync_end`. A `hsync_end` of 0 gives no sync pulse.
- R3: With burst enabled, `burst_gate` is high while `burst_start` <= position < `burst_start`+`burst_len`. The sum is computed one bit wider, so it never wraps. A window that runs past `line_last` is cut at the line end and does not continue into the next line.
- R4: With `burst_en` clear, `burst_gate` stays low for the whole line.
- R5: `hblank` is high while position >= `hblank_start` or position < `hblank_end`. This lets the blanking window straddle the line boundary. A `hblank_end` of 0 leaves only the part from `hblank_start` to the line end.
- R6: `line_start` is high for exactly one clock, at position 0 of every line.
- R7: All configuration inputs, including `burst_en`, are sampled only at the clock edge that begins a line. A change made in mid-line first affects the following line.
- R8: While `en` is low, all four outputs are low from the cycle after `en` is seen low. A later rising `en` starts a fresh line at position 0, using the settings present at that edge.
- R9: During and after synchronous reset, with `en` low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the line at position 0 with outputs low |
| burst_en | input | 1 | Allows the colour-burst gate for the next line |
| line_last | input | 13 | Last position of the line (pixels per line minus one) |
| hsync_end | input | 13 | Number of pixels sync stays high from line start |
| burst_start | input | 13 | First burst position, counted from sync start |
| burst_len | input | 13 | Burst length in pixels |
| hblank_start | input | 13 | First blanking position, counted from sync start |
| hblank_end | input | 13 | First position after the blanking window (wraps across the line start) |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blanking |
| burst_gate | output | 1 | Colour-burst gate |
| line_start | output | 1 | One-cycle strobe at position 0 |

## Verification
The outputs are decoded without extra delay from the registered position and the shadow settings. A value taken at a rising edge therefore shows at the outputs within the same clock period.

The bench drives inputs on falling edges and samples on the next falling edge. When `en` rises, the next sample is position 0 of the new line. When `en` falls, the outputs are low at the very next sample. A settings change made in mid-line is checked against the old values up to the last position of that line. The new values are checked from the sample that follows the wrap.

// File: rtl/tvh_pkg.sv
package tvh_pkg;

    // Width of every horizontal position and length setting
    localparam int POS_W = 13;
    localparam int SUM_W = POS_W + 1;

    typedef logic [POS_W-1:0] pos_t;

    // Per-line settings captured at line start
    typedef struct packed {
        logic burst_en;
        pos_t line_last;
        pos_t hsync_end;
        pos_t burst_start;
        pos_t burst_len;
        pos_t hblank_start;
        pos_t hblank_end;
    } hcfg_t;

    typedef struct packed {
        logic hsync;
        logic hblank;
        logic burst;
        logic lstart;
    } hout_t;

    // lo <= pos < lo + len, sum taken one bit wider so it cannot wrap
    function automatic logic span_hit(pos_t pos, pos_t lo, pos_t len);
        logic [SUM_W-1:0] top;
        top = {1'b0, lo} + {1'b0, len};
        return ({1'b0, pos} >= {1'b0, lo}) && ({1'b0, pos} < top);
    endfunction

    // pos >= a or pos < b: window that may straddle position zero
    function automatic logic ring_hit(pos_t pos, pos_t a, pos_t b);
        return (pos >= a) || (pos < b);
    endfunction

endpackage

// File: rtl/tvh_line_ctrl.sv
module tvh_line_ctrl
    import tvh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  hcfg_t cfg_in,
    output logic  run,
    output pos_t  pos,
    output hcfg_t cfg_q
);

    logic begin_line;

    // A line begins on the first enabled cycle or after the last position
    assign begin_line = !run || (pos == cfg_q.line_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            pos   <= '0;
            cfg_q <= '0;
        end else if (!en) begin
            run <= 1'b0;
            pos <= '0;
        end else if (begin_line) begin
            run   <= 1'b1;
            pos   <= '0;
            cfg_q <= cfg_in;
        end else begin
            pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/tvh_window.sv
module tvh_window
    import tvh_pkg::*;
#(
    parameter bit WRAP = 1'b0
) (
    input  pos_t pos,
    input  pos_t edge_a,
    input  pos_t edge_b,
    output logic hit
);

    generate
        if (WRAP) begin : g_ring
            // edge_a opens, edge_b closes, window may cross position zero
            assign hit = ring_hit(pos, edge_a, edge_b);
        end else begin : g_span
            // edge_a is the first position, edge_b the length
            assign hit = span_hit(pos, edge_a, edge_b);
        end
    endgenerate

endmodule

// File: rtl/tv_hline_gen.sv
module tv_hline_gen
    import tvh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             burst_en,
    input  logic [POS_W-1:0] line_last,
    input  logic [POS_W-1:0] hsync_end,
    input  logic [POS_W-1:0] burst_start,
    input  logic [POS_W-1:0] burst_len,
    input  logic [POS_W-1:0] hblank_start,
    input  logic [POS_W-1:0] hblank_end,
    output logic             hsync,
    output logic             hblank,
    output logic             burst_gate,
    output logic             line_start
);

    hcfg_t cfg_in;
    hcfg_t cfg_q;
    pos_t  pos_q;
    logic  run_q;
    logic  burst_win;
    logic  blank_win;
    hout_t outs;

    always_comb begin
        cfg_in.burst_en     = burst_en;
        cfg_in.line_last    = line_last;
        cfg_in.hsync_end    = hsync_end;
        cfg_in.burst_start  = burst_start;
        cfg_in.burst_len    = burst_len;
        cfg_in.hblank_start = hblank_start;
        cfg_in.hblank_end   = hblank_end;
    end

    tvh_line_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cfg_in (cfg_in),
        .run    (run_q),
        .pos    (pos_q),
        .cfg_q  (cfg_q)
    );

    tvh_window #(.WRAP(1'b0)) u_burst_win (
        .pos    (pos_q),
        .edge_a (cfg_q.burst_start),
        .edge_b (cfg_q.burst_len),
        .hit    (burst_win)
    );

    tvh_window #(.WRAP(1'b1)) u_blank_win (
        .pos    (pos_q),
        .edge_a (cfg_q.hblank_start),
        .edge_b (cfg_q.hblank_end),
        .hit    (blank_win)
    );

    always_comb begin
        outs        = '0;
        if (run_q) begin
            outs.hsync  = pos_q < cfg_q.hsync_end;
            outs.hblank = blank_win;
            outs.burst  = cfg_q.burst_en && burst_win;
            outs.lstart = pos_q == '0;
        end
    end

    assign hsync      = outs.hsync;
    assign hblank     = outs.hblank;
    assign burst_gate = outs.burst;
    assign line_start = outs.lstart;

endmodule

// File: rtl/tvh_hline_chk.sv
module tvh_hline_chk
    import tvh_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  en,
    input logic  run,
    input pos_t  pos,
    input hcfg_t cfg_q,
    input logic  hsync,
    input logic  hblank,
    input logic  burst_gate,
    input logic  line_start
);

    // R1: the position steps by one inside a line
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (en && run && pos != cfg_q.line_last) |=> (pos == $past(pos) + 1'b1));

    // R1: the position returns to zero after the last pixel
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && run && pos == cfg_q.line_last) |=> (pos == '0));

    // R2: no sync at or after its end position
    a_r2_sync_end: assert property (@(posedge clk) disable iff (rst)
        (pos >= cfg_q.hsync_end) |-> !hsync);

    // R4: burst stays low when the captured enable is clear
    a_r4_burst_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.burst_en |-> !burst_gate);

    // R6: the line strobe lasts one cycle unless the line is one pixel long
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (line_start && cfg_q.line_last != '0 && en) |=> !line_start);

    // R7: captured settings do not change inside a line
    a_r7_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        (run && pos != '0) |-> $stable(cfg_q));

    // R8: outputs fall the cycle after enable is seen low
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(hsync || hblank || burst_gate || line_start));

endmodule

bind tv_hline_gen tvh_hline_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .run        (run_q),
    .pos        (pos_q),
    .cfg_q      (cfg_q),
    .hsync      (hsync),
    .hblank     (hblank),
    .burst_gate (burst_gate),
    .line_start (line_start)
);

// File: tb/tv_hline_gen_test.sv
module tv_hline_gen_test;

    typedef struct {
        int last, hs, bs, bl, hbs, hbe;
        bit ben;
    } lcfg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        burst_en = 1'b0;
    logic [12:0] line_last = '0, hsync_end = '0, burst_start = '0;
    logic [12:0] burst_len = '0, hblank_start = '0, hblank_end = '0;
    logic        hsync, hblank, burst_gate, line_start;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tv_hline_gen uut (
        .clk(clk), .rst(rst), .en(en), .burst_en(burst_en),
        .line_last(line_last), .hsync_end(hsync_end),
        .burst_start(burst_start), .burst_len(burst_len),
        .hblank_start(hblank_start), .hblank_end(hblank_end),
        .hsync(hsync), .hblank(hblank), .burst_gate(burst_gate),
        .line_start(line_start)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic apply(lcfg_t c);
        line_last    = 13'(c.last);
        hsync_end    = 13'(c.hs);
        burst_start  = 13'(c.bs);
        burst_len    = 13'(c.bl);
        hblank_start = 13'(c.hbs);
        hblank_end   = 13'(c.hbe);
        burst_en     = c.ben;
    endtask

    task automatic check_idle(string req);
        chk(req, "hsync idle", hsync, 1'b0);
        chk(req, "hblank idle", hblank, 1'b0);
        chk(req, "burst idle", burst_gate, 1'b0);
        chk(req, "line_start idle", line_start, 1'b0);
    endtask

    task automatic check_pos(int p, lcfg_t c);
        chk("R2", $sformatf("hsync p=%0d", p), hsync, p < c.hs);
        chk(c.ben ? "R3" : "R4", $sformatf("burst p=%0d", p), burst_gate,
            c.ben && p >= c.bs && p < c.bs + c.bl);
        chk("R5", $sformatf("hblank p=%0d", p), hblank, p >= c.hbs || p < c.hbe);
        chk("R6", $sformatf("line_start p=%0d", p), line_start, p == 0);
    endtask

    // Called at a falling edge with the design at position 0
    task automatic check_lines(lcfg_t c, int n);
        for (int l = 0; l < n; l++)
            for (int p = 0; p <= c.last; p++) begin
                check_pos(p, c);
                @(negedge clk);
            end
    endtask

    task automatic start(lcfg_t c);
        apply(c);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop();
        en = 1'b0;
        @(negedge clk);
        check_idle("R8");
    endtask

    lcfg_t ca = '{last:19, hs:4, bs:6, bl:3, hbs:15, hbe:8, ben:1'b1};
    lcfg_t cb = '{last:11, hs:2, bs:3, bl:2, hbs:9, hbe:1, ben:1'b1};

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_idle("R9");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R9");
    endtask

    task automatic t_basic();
        start(ca);
        check_lines(ca, 3);   // R1 R2 R3 R5 R6, period of line_last+1
        stop();
    endtask

    task automatic t_burst_off();
        lcfg_t c = ca;
        c.ben = 1'b0;
        start(c);
        check_lines(c, 1);    // R4
        stop();
    endtask

    task automatic t_edges();
        lcfg_t c = '{last:9, hs:0, bs:7, bl:10, hbs:9, hbe:0, ben:1'b1};
        start(c);
        check_lines(c, 2);    // R2 no sync, R3 clipped burst, R5 end of zero
        stop();
    endtask

    task automatic t_cfg_switch();
        start(ca);
        for (int p = 0; p <= ca.last; p++) begin
            check_pos(p, ca);  // R7: old settings hold for the whole line
            if (p == 5) apply(cb);
            @(negedge clk);
        end
        check_lines(cb, 2);   // R7: new settings from the next line
        stop();
    endtask

    task automatic t_disable_mid();
        start(ca);
        for (int p = 0; p < 8; p++) begin
            check_pos(p, ca);
            @(negedge clk);
        end
        en = 1'b0;
        @(negedge clk);
        check_idle("R8");
        repeat (3) @(negedge clk);
        check_idle("R8");
        start(cb);
        check_pos(0, cb);      // R8: fresh line at position 0
        check_lines(cb, 1);
        stop();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_burst_off();
        t_edges();
        t_cfg_switch();
        t_disable_mid();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule